// File: doc/BRIEF.md
# Horizontal Readout Clock and Correlated-Sampling Strobe Generator

This block drives one horizontal readout of an interline CCD. When the line sequencer raises a single-cycle start request, it runs a fixed number of pixel periods. Each period is a whole number of master clock cycles. In every period it produces the two-phase horizontal shift clocks and the output-node reset pulse. It also produces the clamp and sample strobes that an external correlated double sampling front end uses to take the reference level and then the video level of each pixel.

Within a period, the reset pulse comes first. The clamp window follows, while the second-phase clock is still high. The second-phase clock then falls, which dumps charge onto the output node. The sample window comes after that fall. Every offset and width is a parameter counted in master clock cycles.

Each period is tagged with a region flag. The line starts with empty shift phases (dummy), then a leading group of shielded dark columns, then the active pixels, then a trailing group of dark columns. A one-cycle done pulse tells the sequencer that the final charge dump has happened, so it can begin the next vertical transfer.

The second register can run in lockstep with the first (dual mode) or stay parked low (single mode). The mode is captured when the line starts.

Top module: `ccd_hpix_gen`

## Requirements
- R1: Out of reset, and while no line is running, `h1a`=1, `h2`=0, `h1b` follows `dual_mode`, and `rg_clk`, `clamp`, `sample`, all region flags and `line_done` are 0.
- R2: A line start request is sampled on the rising edge P0. Phase 0 of pixel 0 is visible at the outputs after edge P0+1. Each pixel period then lasts `PIX_CYC` cycles. In phases [0, `H2_FALL`) `h2`=1 and `h1a`=0, and in the remaining phases `h2`=0 and `h1a`=1.
- R3: In single mode `h1b` stays 0 for the whole line. In dual mode `h1b` equals `h1a` in every cycle.
- R4: `rg_clk` is high in phases [0, `RST_LEN`) of every period, so it rises together with `h2`.
- R5: `clamp` is high in phases [`CLP_OFF`, `CLP_OFF`+`CLP_LEN`) and `sample` is high in phases [`SMP_OFF`, `SMP_OFF`+`SMP_LEN`). The order within one period is: reset ends, then clamp, then `h2` falls, then sample.
- R6: A line lasts `DUMMY_N`+`LEAD_N`+`ACT_N`+`TRAIL_N` periods. `line_done` is high for exactly one cycle, in the cycle after `h2` falls in the final period.
- R7: Period index i is flagged `pix_dummy` for i < `DUMMY_N`, `pix_dark` for the next `LEAD_N` periods, `pix_active` for the next `ACT_N` periods, and `pix_dark` for the last `TRAIL_N` periods. At most one flag is high at a time, and no flag is high while idle.
- R8: A start request that arrives while a line is running is ignored: the phase sequence and the line length do not change.
- R9: `dual_mode` is captured on the start edge. Changes to it during a line do not affect `h1b` until the line has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, `PIX_CYC` cycles per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Single-cycle request to read out one line |
| dual_mode | input | 1 | 1: second register clocked with the first; 0: parked low |
| h1a | output | 1 | First-phase clock, register A |
| h1b | output | 1 | First-phase clock, register B |
| h2 | output | 1 | Second-phase clock shared by both registers |
| rg_clk | output | 1 | Output-node reset pulse |
| clamp | output | 1 | Reference-level clamp strobe |
| sample | output | 1 | Video-level sample strobe |
| pix_dummy | output | 1 | Current period is an empty shift phase |
| pix_dark | output | 1 | Current period is a shielded dark column |
| pix_active | output | 1 | Current period is an active pixel |
| line_done | output | 1 | One-cycle pulse after the final charge dump |

## Verification
Two events can arrive in the same cycle: a start request and a running line. The bench raises the request, and also flips `dual_mode`, in the middle of a line. The scoreboard expects the unchanged phase sequence, the original `h1b` behaviour and exactly one done pulse at the original position. A second pairing happens inside every period: the `rg_clk` rising edge lands on the `h2` rising edge. The expected per-cycle vector, worked out from the phase windows, checks that both appear together and that the fall of `h2` sits between clamp and sample.

// File: rtl/ccd_hpix_pkg.sv
package ccd_hpix_pkg;

  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_DUMMY  = 2'd1,
    REG_DARK   = 2'd2,
    REG_ACTIVE = 2'd3
  } region_e;

  typedef struct packed {
    logic h1a;
    logic h1b;
    logic h2;
    logic rg;
    logic clamp;
    logic sample;
  } wave_t;

endpackage

// File: rtl/hpix_timebase.sv
module hpix_timebase #(
  parameter int PIX_CYC  = 8,
  parameter int LINE_LEN = 694,
  localparam int PW = $clog2(PIX_CYC),
  localparam int LW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  output logic          running,
  output logic          accept,
  output logic [PW-1:0] phase,
  output logic [LW-1:0] pix_idx
);

  localparam logic [PW-1:0] PH_LAST  = PW'(PIX_CYC - 1);
  localparam logic [LW-1:0] PIX_LAST = LW'(LINE_LEN - 1);

  assign accept = !running && line_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      phase   <= '0;
      pix_idx <= '0;
    end else if (!running) begin
      phase   <= '0;
      pix_idx <= '0;
      if (line_start) running <= 1'b1;
    end else if (phase == PH_LAST) begin
      phase <= '0;
      if (pix_idx == PIX_LAST) running <= 1'b0;
      else                     pix_idx <= pix_idx + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // R8: a start request during a line never disturbs the phase count
  p_phase_adv_r8: assert property (@(posedge clk) disable iff (rst)
    (running && phase != PH_LAST) |=> (running && phase == $past(phase) + 1'b1));

  p_pix_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (running && phase != PH_LAST) |=> $stable(pix_idx));

endmodule

// File: rtl/hpix_wave.sv
module hpix_wave
  import ccd_hpix_pkg::*;
#(
  parameter int PIX_CYC = 8,
  parameter int H2_FALL = 4,
  parameter int RST_LEN = 1,
  parameter int CLP_OFF = 2,
  parameter int CLP_LEN = 2,
  parameter int SMP_OFF = 5,
  parameter int SMP_LEN = 2,
  localparam int PW = $clog2(PIX_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          running,
  input  logic          accept,
  input  logic          dual_mode,
  input  logic [PW-1:0] phase,
  output wave_t         q
);

  localparam logic [PW-1:0] F_H2  = PW'(H2_FALL);
  localparam logic [PW-1:0] E_RG  = PW'(RST_LEN);
  localparam logic [PW-1:0] S_CLP = PW'(CLP_OFF);
  localparam logic [PW-1:0] E_CLP = PW'(CLP_OFF + CLP_LEN);
  localparam logic [PW-1:0] S_SMP = PW'(SMP_OFF);
  localparam int            E_SMP = SMP_OFF + SMP_LEN;

  initial begin
    a_cfg_order_r5: assert (RST_LEN <= CLP_OFF && CLP_OFF + CLP_LEN <= H2_FALL &&
                            H2_FALL <= SMP_OFF && E_SMP <= PIX_CYC &&
                            H2_FALL + 1 < PIX_CYC && RST_LEN > 0)
      else $error("strobe offsets out of order");
  end

  logic  dual_lat;
  wave_t d;

  always_ff @(posedge clk) begin
    if (rst)         dual_lat <= 1'b0;
    else if (accept) dual_lat <= dual_mode;
  end

  always_comb begin
    d = '0;
    if (running) begin
      d.h2     = (phase < F_H2);
      d.h1a    = !(phase < F_H2);
      d.h1b    = dual_lat && !(phase < F_H2);
      d.rg     = (phase < E_RG);
      d.clamp  = (phase >= S_CLP) && (phase < E_CLP);
      d.sample = (phase >= S_SMP) && (32'(phase) < E_SMP);
    end else begin
      d.h1a = 1'b1;
      d.h1b = dual_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '{h1a: 1'b1, default: 1'b0};
    else     q <= d;
  end

  p_h2_compl_r2: assert property (@(posedge clk) disable iff (rst)
    q.h2 |-> !q.h1a);

  p_single_h1b_r3: assert property (@(posedge clk) disable iff (rst)
    (running && !dual_lat) |=> !q.h1b);

  p_rg_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(q.rg) |-> $rose(q.h2));

  p_clamp_order_r5: assert property (@(posedge clk) disable iff (rst)
    q.clamp |-> (!q.rg && q.h2));

  p_sample_order_r5: assert property (@(posedge clk) disable iff (rst)
    q.sample |-> (!q.h2 && !q.clamp && !q.rg));

endmodule

// File: rtl/hpix_region.sv
module hpix_region
  import ccd_hpix_pkg::*;
#(
  parameter int PIX_CYC = 8,
  parameter int H2_FALL = 4,
  parameter int DUMMY_N = 14,
  parameter int LEAD_N  = 8,
  parameter int ACT_N   = 648,
  parameter int TRAIL_N = 24,
  localparam int LINE_LEN = DUMMY_N + LEAD_N + ACT_N + TRAIL_N,
  localparam int PW = $clog2(PIX_CYC),
  localparam int LW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          running,
  input  logic [PW-1:0] phase,
  input  logic [LW-1:0] pix_idx,
  output logic          pix_dummy,
  output logic          pix_dark,
  output logic          pix_active,
  output logic          line_done
);

  localparam int B_LEAD  = DUMMY_N;
  localparam int B_ACT   = DUMMY_N + LEAD_N;
  localparam int B_TRAIL = DUMMY_N + LEAD_N + ACT_N;
  localparam logic [LW-1:0] PIX_LAST = LW'(LINE_LEN - 1);
  localparam logic [PW-1:0] PH_DONE  = PW'(H2_FALL + 1);

  region_e reg_d;

  always_comb begin
    if (!running)                     reg_d = REG_NONE;
    else if (32'(pix_idx) < B_LEAD)   reg_d = REG_DUMMY;
    else if (32'(pix_idx) < B_ACT)    reg_d = REG_DARK;
    else if (32'(pix_idx) < B_TRAIL)  reg_d = REG_ACTIVE;
    else                              reg_d = REG_DARK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_dummy  <= 1'b0;
      pix_dark   <= 1'b0;
      pix_active <= 1'b0;
      line_done  <= 1'b0;
    end else begin
      pix_dummy  <= (reg_d == REG_DUMMY);
      pix_dark   <= (reg_d == REG_DARK);
      pix_active <= (reg_d == REG_ACTIVE);
      line_done  <= running && (pix_idx == PIX_LAST) && (phase == PH_DONE);
    end
  end

  p_flags_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pix_dummy, pix_dark, pix_active}));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    line_done |=> !line_done);

endmodule

// File: rtl/ccd_hpix_gen.sv
module ccd_hpix_gen
  import ccd_hpix_pkg::*;
#(
  parameter int PIX_CYC = 8,
  parameter int H2_FALL = 4,
  parameter int RST_LEN = 1,
  parameter int CLP_OFF = 2,
  parameter int CLP_LEN = 2,
  parameter int SMP_OFF = 5,
  parameter int SMP_LEN = 2,
  parameter int DUMMY_N = 14,
  parameter int LEAD_N  = 8,
  parameter int ACT_N   = 648,
  parameter int TRAIL_N = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic dual_mode,
  output logic h1a,
  output logic h1b,
  output logic h2,
  output logic rg_clk,
  output logic clamp,
  output logic sample,
  output logic pix_dummy,
  output logic pix_dark,
  output logic pix_active,
  output logic line_done
);

  localparam int LINE_LEN = DUMMY_N + LEAD_N + ACT_N + TRAIL_N;
  localparam int PW = $clog2(PIX_CYC);
  localparam int LW = $clog2(LINE_LEN);

  logic          running;
  logic          accept;
  logic [PW-1:0] phase;
  logic [LW-1:0] pix_idx;
  wave_t         wv;

  hpix_timebase #(.PIX_CYC(PIX_CYC), .LINE_LEN(LINE_LEN)) u_tb (
    .clk(clk), .rst(rst), .line_start(line_start),
    .running(running), .accept(accept), .phase(phase), .pix_idx(pix_idx)
  );

  hpix_wave #(
    .PIX_CYC(PIX_CYC), .H2_FALL(H2_FALL), .RST_LEN(RST_LEN),
    .CLP_OFF(CLP_OFF), .CLP_LEN(CLP_LEN), .SMP_OFF(SMP_OFF), .SMP_LEN(SMP_LEN)
  ) u_wave (
    .clk(clk), .rst(rst), .running(running), .accept(accept),
    .dual_mode(dual_mode), .phase(phase), .q(wv)
  );

  hpix_region #(
    .PIX_CYC(PIX_CYC), .H2_FALL(H2_FALL), .DUMMY_N(DUMMY_N),
    .LEAD_N(LEAD_N), .ACT_N(ACT_N), .TRAIL_N(TRAIL_N)
  ) u_region (
    .clk(clk), .rst(rst), .running(running), .phase(phase), .pix_idx(pix_idx),
    .pix_dummy(pix_dummy), .pix_dark(pix_dark), .pix_active(pix_active),
    .line_done(line_done)
  );

  assign h1a    = wv.h1a;
  assign h1b    = wv.h1b;
  assign h2     = wv.h2;
  assign rg_clk = wv.rg;
  assign clamp  = wv.clamp;
  assign sample = wv.sample;

  // R6: done only right after the final second-phase fall
  p_done_after_fall_r6: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (!h2 && !$past(h2) && $past(h2, 2)));

  // R7: flags only while shift clocks are toggling
  p_flags_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!running && !$past(running)) |-> !(pix_dummy || pix_dark || pix_active));

endmodule

// File: tb/ccd_hpix_gen_tb_top.sv
`timescale 1ns/1ps
module ccd_hpix_gen_tb_top;

  localparam int PIX_CYC = 8;
  localparam int H2_FALL = 4;
  localparam int RST_LEN = 1;
  localparam int CLP_OFF = 2;
  localparam int CLP_LEN = 2;
  localparam int SMP_OFF = 5;
  localparam int SMP_LEN = 2;
  localparam int DUMMY_N = 3;
  localparam int LEAD_N  = 2;
  localparam int ACT_N   = 6;
  localparam int TRAIL_N = 4;
  localparam int NPIX    = DUMMY_N + LEAD_N + ACT_N + TRAIL_N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic dual_mode = 1'b0;
  logic h1a, h1b, h2, rg_clk, clamp, sample;
  logic pix_dummy, pix_dark, pix_active, line_done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [9:0] exp_q[$];

  always #4 clk = ~clk;

  ccd_hpix_gen #(
    .PIX_CYC(PIX_CYC), .H2_FALL(H2_FALL), .RST_LEN(RST_LEN),
    .CLP_OFF(CLP_OFF), .CLP_LEN(CLP_LEN), .SMP_OFF(SMP_OFF), .SMP_LEN(SMP_LEN),
    .DUMMY_N(DUMMY_N), .LEAD_N(LEAD_N), .ACT_N(ACT_N), .TRAIL_N(TRAIL_N)
  ) dut_i (
    .clk(clk), .rst(rst), .line_start(line_start), .dual_mode(dual_mode),
    .h1a(h1a), .h1b(h1b), .h2(h2), .rg_clk(rg_clk), .clamp(clamp),
    .sample(sample), .pix_dummy(pix_dummy), .pix_dark(pix_dark),
    .pix_active(pix_active), .line_done(line_done)
  );

  function automatic logic [9:0] outs();
    return {h1a, h1b, h2, rg_clk, clamp, sample, pix_dummy, pix_dark, pix_active, line_done};
  endfunction

  function automatic string tag_of(input logic [9:0] diff);
    if (diff[9] || diff[7]) return "R2";
    if (diff[8])            return "R3/R9";
    if (diff[6])            return "R4";
    if (diff[5] || diff[4]) return "R5";
    if (diff[3:1] != 0)     return "R7";
    return "R6";
  endfunction

  function automatic logic [9:0] expect_at(input int i, input int p, input logic dual);
    logic h2e, dm, dk, ac;
    h2e = (p < H2_FALL);
    dm  = (i < DUMMY_N);
    ac  = (i >= DUMMY_N + LEAD_N) && (i < DUMMY_N + LEAD_N + ACT_N);
    dk  = !dm && !ac;
    return {!h2e, dual & !h2e, h2e, 1'(p < RST_LEN),
            1'(p >= CLP_OFF && p < CLP_OFF + CLP_LEN),
            1'(p >= SMP_OFF && p < SMP_OFF + SMP_LEN),
            dm, dk, ac, 1'(i == NPIX - 1 && p == H2_FALL + 1)};
  endfunction

  // Monitor: pops one expected vector per cycle while a line is scored
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [9:0] e, a;
      e = exp_q.pop_front();
      a = outs();
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: outputs %b expected %b", tag_of(a ^ e), a, e);
      end
    end
  end

  task automatic check_idle(input logic dual, input string req);
    logic [9:0] e;
    @(negedge clk);
    e = {1'b1, dual, 8'b0};
    tests++;
    if (outs() !== e) begin
      fails++;
      $display("FAIL %s: idle outputs %b expected %b", req, outs(), e);
    end
  endtask

  // Driver: starts a line and pushes every expected cycle into the queue
  task automatic run_line(input logic dual, input bit disturb);
    @(posedge clk); #1;
    dual_mode  = dual;
    line_start = 1'b1;
    @(posedge clk); #1;
    line_start = 1'b0;
    exp_q.push_back({1'b1, dual, 8'b0});
    for (int i = 0; i < NPIX; i++)
      for (int p = 0; p < PIX_CYC; p++)
        exp_q.push_back(expect_at(i, p, dual));
    for (int c = 0; c < NPIX * PIX_CYC; c++) begin
      @(posedge clk); #1;
      // R8 and R9: request and mode flip in the middle of a line
      if (disturb && c == 10) begin line_start = 1'b1; dual_mode = !dual; end
      if (disturb && c == 11) line_start = 1'b0;
      if (disturb && c == 40) begin line_start = 1'b1; end
      if (disturb && c == 41) line_start = 1'b0;
      if (disturb && c == 60) dual_mode = dual;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check_idle(1'b0, "R1");                  // R1 reset state
    @(posedge clk); #1 dual_mode = 1'b1;
    @(posedge clk);
    check_idle(1'b1, "R1");                  // R1/R3 idle h1b follows mode
    @(posedge clk); #1 dual_mode = 1'b0;
    @(posedge clk);
    run_line(1'b0, 1'b0);                    // R2 R4 R5 R6 R7 single mode
    run_line(1'b1, 1'b0);                    // R3 dual mode
    run_line(1'b0, 1'b1);                    // R8 R9 single, disturbed
    run_line(1'b1, 1'b1);                    // R8 R9 dual, disturbed
    repeat (4) @(posedge clk);
    check_idle(1'b1, "R1");
    while (exp_q.size() > 0) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule